// File: doc/BRIEF.md
# CAN FD CRC Field Serializer

This block handles the CRC field of a CAN FD protocol engine in both directions. When the field begins, one parallel load takes the CRC of the selected length (15, 17 or 21 bits) into a left-aligned transmit shift register. Each bit enable then moves the register by one position, so the transmit bit is always read from a single fixed position, most significant bit first. No bit is picked out of a CRC vector by an index that changes every bit.

In the same bit slots, the receive side shifts the incoming serial bit into a second register. A down-counter tracks how many bits are still to come. Once the counter is empty, the block raises a done flag. It also raises a match flag when the received bits, masked to the selected width, equal the CRC that was latched at the start of the field. Computing the CRC and handling bit stuffing belong to other blocks.

Top module: `can_crc_serializer`

## Requirements
- R1: After reset, and until the first field start: `tx_bit_o` is 1, and `done_o` and `match_o` are 0.
- R2: A `field_start_i` pulse latches both `len_sel_i` and the CRC of that length. The encoding is 0 = 15 bits, 1 = 17 bits, 2 = 21 bits, and 3 is treated as 21 bits. On the clock edge after the pulse, `tx_bit_o` shows that CRC's most significant bit. A later change of `len_sel_i` or of the CRC inputs has no effect until the next start.
- R3: Bits leave the block most significant first. The block moves on one bit per clock in which `bit_en_i` is high, and in any other clock it holds.
- R4: `done_o` rises after exactly 15, 17 or 21 enabled shifts, matching the latched length. It then stays high until the next field start.
- R5: When `done_o` is high, `match_o` is high exactly when every received bit equals the matching bit of the latched CRC. The first received bit is compared with the most significant bit.
- R6: Only the latched width takes part in the compare. A single wrong received bit in any position of the field clears `match_o`.
- R7: A field start aborts any shift in progress, reloads the registers and restarts the count. It takes priority over a `bit_en_i` in the same clock.
- R8: Bit enables after `done_o` has risen are ignored: `tx_bit_o`, `done_o` and `match_o` keep their values.
- R9: Whenever no field is shifting (idle or done), `tx_bit_o` is 1, the recessive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| len_sel_i | input | 2 | CRC length select (0:15, 1:17, 2/3:21) |
| crc15_i | input | 15 | Computed 15-bit CRC |
| crc17_i | input | 17 | Computed 17-bit CRC |
| crc21_i | input | 21 | Computed 21-bit CRC |
| field_start_i | input | 1 | CRC field start pulse |
| bit_en_i | input | 1 | Sample-point bit enable |
| rx_bit_i | input | 1 | Received serial bit |
| tx_bit_o | output | 1 | Transmit bit |
| done_o | output | 1 | All CRC bits shifted |
| match_o | output | 1 | Received CRC equals latched CRC |

## Verification
The bench aims at the ends of the field. A counter that is off by one would raise `done_o` one shift early or late, on one of the three lengths or on all of them. A restart issued while a field is shifting, or in the same clock as an enable, would leave stale bits in the transmit stream if the reload lost to the shift. Enables held on after the field is done would corrupt `match_o` or drive a dominant bit if they were not ignored. Two more faults are targeted. A length select that changes mid-field would move the bit count if it were not latched. A single flipped receive bit at the first or the last position would go unnoticed if the compare mask or the bit order were wrong.

// File: rtl/crc_ser_pkg.sv
package crc_ser_pkg;
  typedef enum logic [1:0] {
    CRC_SEL_15 = 2'd0,
    CRC_SEL_17 = 2'd1,
    CRC_SEL_21 = 2'd2
  } crc_sel_e;
endpackage

// File: rtl/crc_bit_counter.sv
module crc_bit_counter #(
  parameter int MAXW = 21,
  localparam int CW = $clog2(MAXW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  input  logic          step_i,
  output logic          busy_o,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= len_i;
      act_q <= 1'b1;
    end else if (step_i && act_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = act_q && (cnt_q != '0);
  assign done_o = act_q && (cnt_q == '0);

  a_r4_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= MAXW);
  a_r4_cnt_one_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && busy_o) |=> (int'(cnt_q) >= int'($past(cnt_q)) - 1));
endmodule

// File: rtl/crc_tx_shifter.sv
module crc_tx_shifter #(
  parameter int MAXW = 21
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [MAXW-1:0] val_i,
  input  logic            step_i,
  output logic            msb_o
);
  logic [MAXW-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '1;
    else if (load_i)  sr_q <= val_i;
    else if (step_i)  sr_q <= {sr_q[MAXW-2:0], 1'b1};
  end

  assign msb_o = sr_q[MAXW-1];
endmodule

// File: rtl/crc_rx_shifter.sv
module crc_rx_shifter #(
  parameter int MAXW = 21
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            step_i,
  input  logic            bit_i,
  output logic [MAXW-1:0] val_o
);
  logic [MAXW-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (clear_i) sr_q <= '0;
    else if (step_i)  sr_q <= {sr_q[MAXW-2:0], bit_i};
  end

  assign val_o = sr_q;
endmodule

// File: rtl/can_crc_serializer.sv
module can_crc_serializer
  import crc_ser_pkg::*;
#(
  parameter int W_A = 15,
  parameter int W_B = 17,
  parameter int W_C = 21,
  localparam int MAXW = W_C,
  localparam int CW = $clog2(MAXW + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [1:0]     len_sel_i,
  input  logic [W_A-1:0] crc15_i,
  input  logic [W_B-1:0] crc17_i,
  input  logic [W_C-1:0] crc21_i,
  input  logic           field_start_i,
  input  logic           bit_en_i,
  input  logic           rx_bit_i,
  output logic           tx_bit_o,
  output logic           done_o,
  output logic           match_o
);
  logic [CW-1:0]   len_d, len_q;
  logic [MAXW-1:0] exp_d, exp_q, aligned_d, rx_val, mask;
  logic            busy, cnt_done, step, tx_msb;

  always_comb begin
    unique case (crc_sel_e'(len_sel_i))
      CRC_SEL_15: begin
        len_d = CW'(W_A);
        exp_d = MAXW'(crc15_i);
      end
      CRC_SEL_17: begin
        len_d = CW'(W_B);
        exp_d = MAXW'(crc17_i);
      end
      default: begin
        len_d = CW'(W_C);
        exp_d = MAXW'(crc21_i);
      end
    endcase
    // left-align so the first bit always sits at the MSB
    aligned_d = exp_d << (CW'(MAXW) - len_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= CW'(W_C);
      exp_q <= '0;
    end else if (field_start_i) begin
      len_q <= len_d;
      exp_q <= exp_d;
    end
  end

  assign step = bit_en_i && busy && !field_start_i;

  crc_bit_counter #(.MAXW(MAXW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (field_start_i),
    .len_i  (len_d),
    .step_i (step),
    .busy_o (busy),
    .done_o (cnt_done)
  );

  crc_tx_shifter #(.MAXW(MAXW)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (field_start_i),
    .val_i  (aligned_d),
    .step_i (step),
    .msb_o  (tx_msb)
  );

  crc_rx_shifter #(.MAXW(MAXW)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (field_start_i),
    .step_i  (step),
    .bit_i   (rx_bit_i),
    .val_o   (rx_val)
  );

  // len_q == MAXW wraps the shift to zero, giving all ones
  assign mask     = (MAXW'(1) << len_q) - MAXW'(1);
  assign tx_bit_o = busy ? tx_msb : 1'b1;
  assign done_o   = cnt_done;
  assign match_o  = cnt_done && (((rx_val ^ exp_q) & mask) == '0);

  a_r4_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !field_start_i) |=> done_o);
  a_r7_start_clears_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_start_i |=> !done_o);
  a_r5_match_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> done_o);
  a_r9_recessive_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> tx_bit_o);
  a_r3_hold_without_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_en_i && !field_start_i) |=> ($stable(tx_bit_o) && $stable(done_o)));
  a_r8_match_stable_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !field_start_i) |=> $stable(match_o));
endmodule

// File: tb/can_crc_serializer_test.sv
module can_crc_serializer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [14:0] c15 = '0;
  logic [16:0] c17 = '0;
  logic [20:0] c21 = '0;
  logic        fs = 1'b0, en = 1'b0, rx = 1'b0;
  logic        tx_o, done_o, match_o;

  int n_tests = 0;
  int n_fail  = 0;

  // reference model state
  int   m_len = 21;
  int   m_cnt = 0;
  bit   m_act = 1'b0;
  logic [20:0] m_exp = '0;
  logic m_rx[$];

  always #5 clk = ~clk;

  can_crc_serializer uut (
    .clk_i(clk), .rst_ni(rst_n), .len_sel_i(sel),
    .crc15_i(c15), .crc17_i(c17), .crc21_i(c21),
    .field_start_i(fs), .bit_en_i(en), .rx_bit_i(rx),
    .tx_bit_o(tx_o), .done_o(done_o), .match_o(match_o)
  );

  function automatic logic exp_tx();
    return (m_act && m_cnt > 0) ? m_exp[m_cnt-1] : 1'b1;
  endfunction
  function automatic logic exp_done();
    return m_act && m_cnt == 0;
  endfunction
  function automatic logic exp_match();
    if (!exp_done()) return 1'b0;
    foreach (m_rx[i]) if (m_rx[i] !== m_exp[m_len-1-i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(string req);
    check(req, tx_o, exp_tx(), "tx_bit");
    check(req, done_o, exp_done(), "done");
    check(req, match_o, exp_match(), "match");
  endtask

  task automatic model_edge();
    if (fs) begin
      m_len = (sel == 2'd0) ? 15 : (sel == 2'd1) ? 17 : 21;
      m_exp = (sel == 2'd0) ? 21'(c15) : (sel == 2'd1) ? 21'(c17) : c21;
      m_cnt = m_len;
      m_act = 1'b1;
      m_rx.delete();
    end else if (en && m_act && m_cnt > 0) begin
      m_rx.push_back(rx);
      m_cnt--;
    end
  endtask

  task automatic step(bit f, bit e, bit r, string req);
    fs = f; en = e; rx = r;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all(req);
  endtask

  // rx bit mirrors the expected CRC bit, flipped at position flip_idx (-1: none)
  task automatic run_bits(int flip_idx, int gap, string req);
    int pos = 0;
    while (m_cnt > 0) begin
      repeat (gap) step(0, 0, 0, "R3");
      step(0, 1, m_exp[m_cnt-1] ^ (pos == flip_idx), req);
      pos++;
    end
  endtask

  task automatic start_field(logic [1:0] s, string req);
    sel = s;
    step(1, 0, 0, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");
    step(0, 1, 1, "R9");  // enable while idle: still recessive

    // 15-bit, continuous enables, clean receive
    c15 = 15'h5A3C; c17 = 17'h1F0F1; c21 = 21'h1ABCDE;
    start_field(2'd0, "R2");
    check("R2", tx_o, c15[14], "first bit msb");
    run_bits(-1, 0, "R3");
    check("R4", done_o, 1'b1, "done after 15");
    check("R5", match_o, 1'b1, "match 15");
    repeat (4) step(0, 1, 0, "R8");
    check("R8", match_o, 1'b1, "match held after extra enables");
    check("R9", tx_o, 1'b1, "recessive after done");

    // 17-bit with gaps, last bit wrong
    start_field(2'd1, "R2");
    sel = 2'd0; c17 = 17'h0;  // changes after start: must not matter
    run_bits(16, 2, "R3");
    check("R4", done_o, 1'b1, "done after 17");
    check("R6", match_o, 1'b0, "mismatch last bit");

    // 21-bit, first bit wrong
    c21 = 21'h0F00F1;
    start_field(2'd2, "R2");
    run_bits(0, 1, "R3");
    check("R6", match_o, 1'b0, "mismatch first bit");

    // 21-bit clean, select value 3
    c21 = 21'h155AA3;
    start_field(2'd3, "R2");
    run_bits(-1, 0, "R3");
    check("R5", match_o, 1'b1, "match 21 via sel 3");

    // abort mid-field and reload with another length
    c15 = 15'h7FFE; c17 = 17'h12345;
    start_field(2'd2, "R7");
    repeat (5) step(0, 1, 0, "R7");
    start_field(2'd1, "R7");
    check("R7", tx_o, c17[16], "reload msb");
    run_bits(-1, 0, "R7");
    check("R4", done_o, 1'b1, "done after restart");
    check("R5", match_o, 1'b1, "match after restart");

    // start and enable in the same clock: start wins
    c15 = 15'h4001;
    sel = 2'd0;
    step(1, 1, 1, "R7");
    check("R7", tx_o, 1'b1, "start beats enable, msb of 0x4001");
    step(0, 1, 1, "R3");
    check("R3", tx_o, 1'b0, "second bit");
    run_bits(-1, 0, "R3");
    check("R5", match_o, 1'b1, "match after concurrent start");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule